// File: doc/BRIEF.md
# Search/Update Time-Slice Memory Arbiter

This block lets two clients share one wide single-port SRAM that holds a lookup database. The clients are a Search engine, which only reads, and an Update engine, which reads and writes. Access follows a fixed time-slice schedule. Search owns a run of consecutive memory cycles, then Update owns a shorter run, and the schedule repeats forever. The run lengths are parameters and default to 20 and 2. This way Update can take a few cycles from Search while lowering Search throughput by only a small, known fraction.

The slot owner is fixed by the schedule alone. If the owner has no request in its slot, that slot stays idle and the other client does not get it. Every access therefore happens at a predictable time. A Search request held through an Update run waits at most as many cycles as that run is long.

The memory side is combinational. Enable, write enable, address and write data are driven in the cycle a request is granted. Read data returns one cycle later and is steered to the client that issued the read by a delayed owner tag. The data word is a parameter and may be around a thousand bits wide.

Top module: `tsm_arbiter`

## Requirements
- R1: After reset is released, Search owns the first S_SLOTS cycles and Update owns the next U_SLOTS cycles. This S_SLOTS + U_SLOTS pattern repeats without end (defaults 20 and 2). A reset restarts the pattern at the first Search slot.
- R2: `srch_gnt` is high exactly in the cycles that Search owns and in which `srch_req` is high. `upd_gnt` is high exactly in the cycles that Update owns and in which `upd_req` is high. The two grants are never high together.
- R3: A slot whose owner is not requesting stays idle: the other client gets no grant in it and `mem_en` stays low.
- R4: `mem_en` is high in exactly the cycles with a grant. In those cycles `mem_addr` equals the address of the granted client.
- R5: Search cannot write. `mem_we` is high only when `upd_gnt` and `upd_we` are both high, and then `mem_wdata` equals `upd_wdata`.
- R6: One cycle after a granted read, the issuing client's read-valid is high and its read-data port carries `mem_rdata`. The other client's read-valid is low. A granted write produces no read-valid. While a read-valid is low, its read-data port reads zero (default RDATA_GATE = 1).
- R7: While `rst_n` is low, both grants, `mem_en`, `mem_we` and both read-valids are low.
- R8: A Search request held high is granted within U_SLOTS cycles. An Update request held high is granted within S_SLOTS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_req | input | 1 | Search read request |
| srch_addr | input | ADDR_W | Search read address |
| srch_gnt | output | 1 | Search request accepted this cycle |
| srch_rvalid | output | 1 | Search read data valid |
| srch_rdata | output | DATA_W | Search read data |
| upd_req | input | 1 | Update request |
| upd_we | input | 1 | Update request is a write |
| upd_addr | input | ADDR_W | Update address |
| upd_wdata | input | DATA_W | Update write data |
| upd_gnt | output | 1 | Update request accepted this cycle |
| upd_rvalid | output | 1 | Update read data valid |
| upd_rdata | output | DATA_W | Update read data |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after the access |

## Verification
The table walk runs three full schedule periods under an eight-entry cycle of request patterns, covering:
- both clients requesting together, which checks that ownership alone decides the grant;
- only the non-owner requesting, which shows idle slots are not handed over;
- Update writes followed by reads of the same address, which shows the write data reached memory and the returned word is steered to the right client.

A directed test holds both requests high across a reset. It checks that grants are suppressed during reset and that the schedule restarts from the first Search slot. It also confirms that a held Search request waits exactly two cycles across the Update run.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

   typedef enum logic {
      OWN_SEARCH = 1'b0,
      OWN_UPDATE = 1'b1
   } owner_e;

   function automatic int unsigned tsm_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned tsm_cnt_w(input int unsigned run_max);
      return (run_max > 1) ? $clog2(run_max) : 1;
   endfunction

endpackage

// File: rtl/tsm_slot_sched.sv
module tsm_slot_sched
   import tsm_pkg::*;
#(
   parameter int unsigned S_SLOTS = 20,
   parameter int unsigned U_SLOTS = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   output owner_e owner_o
);

   localparam int unsigned RUN_MAX = tsm_max(S_SLOTS, U_SLOTS);
   localparam int unsigned CNT_W   = tsm_cnt_w(RUN_MAX);

   owner_e ph_q;

   generate
      if (S_SLOTS == 1 && U_SLOTS == 1) begin : g_toggle
         // one slot each: the phase simply alternates every cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= OWN_SEARCH;
            else        ph_q <= (ph_q == OWN_SEARCH) ? OWN_UPDATE : OWN_SEARCH;
         end
      end else begin : g_count
         localparam logic [CNT_W-1:0] S_LAST = CNT_W'(S_SLOTS - 1);
         localparam logic [CNT_W-1:0] U_LAST = CNT_W'(U_SLOTS - 1);

         logic [CNT_W-1:0] cnt_q;
         logic             run_end;

         always_comb begin
            if (ph_q == OWN_SEARCH) run_end = (cnt_q == S_LAST);
            else                    run_end = (cnt_q == U_LAST);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph_q  <= OWN_SEARCH;
               cnt_q <= '0;
            end else if (run_end) begin
               ph_q  <= (ph_q == OWN_SEARCH) ? OWN_UPDATE : OWN_SEARCH;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign owner_o = ph_q;

endmodule

// File: rtl/tsm_port_mux.sv
module tsm_port_mux
   import tsm_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 256
) (
   input  logic              rst_n,
   input  owner_e            owner_i,
   input  logic              srch_req,
   input  logic [ADDR_W-1:0] srch_addr,
   input  logic              upd_req,
   input  logic              upd_we,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [DATA_W-1:0] upd_wdata,
   output logic              srch_gnt,
   output logic              upd_gnt,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              iss_rd,
   output owner_e            iss_tag
);

   logic s_slot;
   logic u_slot;

   always_comb begin
      // slot ownership never depends on the other client's request
      s_slot   = rst_n && (owner_i == OWN_SEARCH);
      u_slot   = rst_n && (owner_i == OWN_UPDATE);
      srch_gnt = s_slot && srch_req;
      upd_gnt  = u_slot && upd_req;
      mem_en   = srch_gnt || upd_gnt;
      mem_we   = upd_gnt && upd_we;
      mem_addr  = '0;
      mem_wdata = '0;
      if (srch_gnt) begin
         mem_addr = srch_addr;
      end else if (upd_gnt) begin
         mem_addr = upd_addr;
         if (upd_we) mem_wdata = upd_wdata;
      end
      iss_rd  = srch_gnt || (upd_gnt && !upd_we);
      iss_tag = owner_i;
   end

endmodule

// File: rtl/tsm_rd_steer.sv
module tsm_rd_steer
   import tsm_pkg::*;
#(
   parameter int unsigned DATA_W     = 256,
   parameter bit          RDATA_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_rd,
   input  owner_e            iss_tag,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              srch_rvalid,
   output logic [DATA_W-1:0] srch_rdata,
   output logic              upd_rvalid,
   output logic [DATA_W-1:0] upd_rdata
);

   logic   pend_q;
   owner_e tag_q;

   // one register stage matches the fixed one-cycle memory read latency
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         tag_q  <= OWN_SEARCH;
      end else begin
         pend_q <= iss_rd;
         tag_q  <= iss_tag;
      end
   end

   assign srch_rvalid = pend_q && (tag_q == OWN_SEARCH);
   assign upd_rvalid  = pend_q && (tag_q == OWN_UPDATE);

   generate
      if (RDATA_GATE) begin : g_gate
         assign srch_rdata = srch_rvalid ? mem_rdata : '0;
         assign upd_rdata  = upd_rvalid  ? mem_rdata : '0;
      end else begin : g_pass
         assign srch_rdata = mem_rdata;
         assign upd_rdata  = mem_rdata;
      end
   endgenerate

endmodule

// File: rtl/tsm_arbiter.sv
module tsm_arbiter
   import tsm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 256,
   parameter int unsigned S_SLOTS    = 20,
   parameter int unsigned U_SLOTS    = 2,
   parameter bit          RDATA_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srch_req,
   input  logic [ADDR_W-1:0] srch_addr,
   output logic              srch_gnt,
   output logic              srch_rvalid,
   output logic [DATA_W-1:0] srch_rdata,
   input  logic              upd_req,
   input  logic              upd_we,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [DATA_W-1:0] upd_wdata,
   output logic              upd_gnt,
   output logic              upd_rvalid,
   output logic [DATA_W-1:0] upd_rdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (S_SLOTS < 1 || U_SLOTS < 1) begin : g_bad_slots
         $error("tsm_arbiter: S_SLOTS and U_SLOTS must both be at least 1");
      end
      if (DATA_W < 1 || DATA_W > 1024) begin : g_bad_data
         $error("tsm_arbiter: DATA_W must be within 1..1024");
      end
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("tsm_arbiter: ADDR_W must be within 1..32");
      end
   endgenerate

   owner_e owner;
   logic   iss_rd;
   owner_e iss_tag;

   tsm_slot_sched #(
      .S_SLOTS (S_SLOTS),
      .U_SLOTS (U_SLOTS)
   ) sched_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .owner_o (owner)
   );

   tsm_port_mux #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) mux_i (
      .rst_n     (rst_n),
      .owner_i   (owner),
      .srch_req  (srch_req),
      .srch_addr (srch_addr),
      .upd_req   (upd_req),
      .upd_we    (upd_we),
      .upd_addr  (upd_addr),
      .upd_wdata (upd_wdata),
      .srch_gnt  (srch_gnt),
      .upd_gnt   (upd_gnt),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .iss_rd    (iss_rd),
      .iss_tag   (iss_tag)
   );

   tsm_rd_steer #(
      .DATA_W     (DATA_W),
      .RDATA_GATE (RDATA_GATE)
   ) steer_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .iss_rd      (iss_rd),
      .iss_tag     (iss_tag),
      .mem_rdata   (mem_rdata),
      .srch_rvalid (srch_rvalid),
      .srch_rdata  (srch_rdata),
      .upd_rvalid  (upd_rvalid),
      .upd_rdata   (upd_rdata)
   );

endmodule

// File: rtl/tsm_arbiter_chk.sv
module tsm_arbiter_chk #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 256,
   parameter int unsigned S_SLOTS    = 20,
   parameter int unsigned U_SLOTS    = 2,
   parameter bit          RDATA_GATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              srch_req,
   input logic [ADDR_W-1:0] srch_addr,
   input logic              srch_gnt,
   input logic              srch_rvalid,
   input logic [DATA_W-1:0] srch_rdata,
   input logic              upd_req,
   input logic              upd_we,
   input logic [ADDR_W-1:0] upd_addr,
   input logic [DATA_W-1:0] upd_wdata,
   input logic              upd_gnt,
   input logic              upd_rvalid,
   input logic [DATA_W-1:0] upd_rdata,
   input logic              mem_en,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata
);

   logic [15:0] s_wait_q;
   logic [15:0] u_wait_q;
   logic [15:0] u_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_wait_q <= '0;
         u_wait_q <= '0;
         u_run_q  <= '0;
      end else begin
         s_wait_q <= (srch_req && !srch_gnt && s_wait_q != 16'hFFFF) ? s_wait_q + 1'b1 : '0;
         u_wait_q <= (upd_req && !upd_gnt && u_wait_q != 16'hFFFF) ? u_wait_q + 1'b1 : '0;
         u_run_q  <= (upd_gnt && u_run_q != 16'hFFFF) ? u_run_q + 1'b1 : '0;
      end
   end

   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(srch_gnt && upd_gnt));

   p_no_lend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_gnt |-> srch_req) and (upd_gnt |-> upd_req));

   p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_gnt |-> (mem_en && mem_addr == srch_addr)) and
      (upd_gnt  |-> (mem_en && mem_addr == upd_addr)));

   p_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (upd_gnt && upd_we && mem_wdata == upd_wdata));

   p_srd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      srch_gnt |=> (srch_rvalid && !upd_rvalid && srch_rdata == mem_rdata));

   p_urd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_gnt && !upd_we) |=> (upd_rvalid && !srch_rvalid && upd_rdata == mem_rdata));

   p_wr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_gnt && upd_we) |=> (!upd_rvalid && !srch_rvalid));

   p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      RDATA_GATE |-> ((!srch_rvalid |-> srch_rdata == '0) and (!upd_rvalid |-> upd_rdata == '0)));

   p_srch_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      s_wait_q <= 16'(U_SLOTS));

   p_upd_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      u_wait_q <= 16'(S_SLOTS));

   p_upd_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
      u_run_q <= 16'(U_SLOTS));

   always_comb begin
      if (!rst_n) begin
         a_reset_quiet_r7: assert (!srch_gnt && !upd_gnt && !mem_en && !mem_we);
      end
   end

endmodule

bind tsm_arbiter tsm_arbiter_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .S_SLOTS    (S_SLOTS),
   .U_SLOTS    (U_SLOTS),
   .RDATA_GATE (RDATA_GATE)
) chk_i (.*);

// File: tb/tsm_arbiter_tb_top.sv
module tsm_arbiter_tb_top;

   localparam int AW    = 16;
   localparam int DW    = 256;
   localparam int S     = 20;
   localparam int K     = 2;
   localparam int FRAME = S + K;

   // pattern bits: {srch_req, upd_req, upd_we}
   localparam logic [2:0] PAT [8] = '{3'b111, 3'b110, 3'b011, 3'b110,
                                      3'b010, 3'b101, 3'b100, 3'b000};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic          srch_req = 1'b0, upd_req = 1'b0, upd_we = 1'b0;
   logic [AW-1:0] srch_addr = '0, upd_addr = '0;
   logic [DW-1:0] upd_wdata = '0;
   logic          srch_gnt, srch_rvalid, upd_gnt, upd_rvalid, mem_en, mem_we;
   logic [DW-1:0] srch_rdata, upd_rdata, mem_wdata, mem_rdata;
   logic [AW-1:0] mem_addr;

   tsm_arbiter dut_i (
      .clk (clk), .rst_n (rst_n),
      .srch_req (srch_req), .srch_addr (srch_addr), .srch_gnt (srch_gnt),
      .srch_rvalid (srch_rvalid), .srch_rdata (srch_rdata),
      .upd_req (upd_req), .upd_we (upd_we), .upd_addr (upd_addr),
      .upd_wdata (upd_wdata), .upd_gnt (upd_gnt),
      .upd_rvalid (upd_rvalid), .upd_rdata (upd_rdata),
      .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
      .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
   );

   // memory model: one-cycle read latency
   logic [DW-1:0] mem [256];
   logic [DW-1:0] rd_q = '0;
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
         else        rd_q <= mem[mem_addr[7:0]];
      end
   end
   assign mem_rdata = rd_q;

   logic [DW-1:0] shadow [256];
   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   function automatic logic [DW-1:0] init_word(input int a);
      return {8{32'hA5000000 | 32'(a)}};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   logic          pend_s, pend_u;
   logic [DW-1:0] exp_rd;

   task automatic chk_return(input string tag);
      chk("R6", {tag, " srch_rvalid"}, DW'(srch_rvalid), DW'(pend_s));
      chk("R6", {tag, " upd_rvalid"},  DW'(upd_rvalid),  DW'(pend_u));
      chk("R6", {tag, " srch_rdata"}, srch_rdata, pend_s ? exp_rd : '0);
      chk("R6", {tag, " upd_rdata"},  upd_rdata,  pend_u ? exp_rd : '0);
   endtask

   initial begin
      for (int a = 0; a < 256; a++) begin
         mem[a]    = init_word(a);
         shadow[a] = init_word(a);
      end
      pend_s = 1'b0;
      pend_u = 1'b0;
      exp_rd = '0;

      // R7: reset state with both clients requesting
      srch_req = 1'b1;
      upd_req  = 1'b1;
      repeat (3) @(negedge clk);
      #5;
      chk("R7", "srch_gnt in reset", DW'(srch_gnt), '0);
      chk("R7", "upd_gnt in reset",  DW'(upd_gnt),  '0);
      chk("R7", "mem_en in reset",   DW'(mem_en),   '0);
      chk("R7", "rvalid in reset",   DW'(srch_rvalid | upd_rvalid), '0);
      srch_req = 1'b0;
      upd_req  = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      // table walk over three schedule periods
      for (int i = 0; i < 3 * FRAME; i++) begin
         logic [2:0] p;
         logic own_s, eg_s, eg_u;
         logic [AW-1:0] ea;
         chk_return("walk");
         p         = PAT[i % 8];
         srch_req  = p[2];
         upd_req   = p[1];
         upd_we    = p[0];
         srch_addr = AW'((i * 3) & 255);
         upd_addr  = AW'(i >> 1);
         upd_wdata = {8{32'hC0DE0000 + 32'(i)}};
         #5;
         own_s = (i % FRAME) < S;
         eg_s  = own_s && srch_req;
         eg_u  = !own_s && upd_req;
         chk("R2", "srch_gnt", DW'(srch_gnt), DW'(eg_s));
         chk("R2", "upd_gnt",  DW'(upd_gnt),  DW'(eg_u));
         if (!eg_s && !eg_u) chk("R3", "idle slot mem_en", DW'(mem_en), '0);
         chk("R4", "mem_en", DW'(mem_en), DW'(eg_s || eg_u));
         ea = eg_s ? srch_addr : upd_addr;
         if (eg_s || eg_u) chk("R4", "mem_addr", DW'(mem_addr), DW'(ea));
         chk("R5", "mem_we", DW'(mem_we), DW'(eg_u && upd_we));
         if (eg_u && upd_we) chk("R5", "mem_wdata", mem_wdata, upd_wdata);
         pend_s = eg_s;
         pend_u = eg_u && !upd_we;
         exp_rd = shadow[ea[7:0]];
         if (eg_u && upd_we) shadow[upd_addr[7:0]] = upd_wdata;
         @(negedge clk);
      end
      chk_return("walk end");

      // directed: reset mid-run, then schedule restart and held-request wait
      srch_req = 1'b1;
      upd_req  = 1'b1;
      upd_we   = 1'b0;
      rst_n    = 1'b0;
      #5;
      chk("R7", "srch_gnt mid reset", DW'(srch_gnt), '0);
      chk("R7", "upd_gnt mid reset",  DW'(upd_gnt),  '0);
      chk("R7", "mem_we mid reset",   DW'(mem_we),   '0);
      chk("R7", "rvalid mid reset",   DW'(srch_rvalid | upd_rvalid), '0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i <= FRAME; i++) begin
         #5;
         chk("R1", "srch_gnt restart", DW'(srch_gnt), DW'((i % FRAME) < S));
         chk("R1", "upd_gnt restart",  DW'(upd_gnt),  DW'((i % FRAME) >= S));
         @(negedge clk);
      end
      // R8: held search request waited exactly K cycles across the update run
      #5;
      chk("R8", "srch_gnt after wait", DW'(srch_gnt), DW'(1));
      srch_req = 1'b0;
      upd_req  = 1'b0;
      @(negedge clk);
      finish_run();
   end

endmodule